// File: doc/BRIEF.md
# Four-Element Replicating Structure Loader

This unit carries out one SIMD load of a four-element structure. It reads four consecutive elements from memory, one request per element. Each element is copied into every lane of its own 64-bit vector register, and four such registers are written. The caller supplies the decoded instruction fields, the base register value and the index register value, then pulses `start`. The unit checks the encoding, the register range and the alignment. It then fetches the four elements, writes the four destination registers and finally updates the base register if the encoding asks for it.

The memory request is a valid/ready stream. `rd_valid` rises with `rd_addr` and `rd_bytes` and holds them unchanged until a cycle in which `rd_ready` is high. The handshake happens on that edge. Only one read is outstanding at a time. The element comes back later on `rsp_valid`/`rsp_data`. The unit always accepts a response, so the response side has no ready. The register-file and base writeback ports are plain one-cycle write strobes. The three outcome flags are valid only while `done` is high.

Top module: `quad_splat_loader`

## Requirements
- R1: `fld_size` selects the element width in bytes (ebytes): 00 gives 1, 01 gives 2, 10 and 11 give 4. `rd_bytes` carries ebytes with every read request.
- R2: When `fld_size` is 11 and `fld_a` is 0, the operation ends with `undef_flag` high during `done`. No read, register write or base writeback takes place.
- R3: Each destination register receives its element copied into every lane, in the low ebytes bytes of each lane. That gives 8 lanes of 8 bits, 4 lanes of 16 bits, or 2 lanes of 32 bits.
- R4: The first destination index is {fld_d, fld_vd}, with fld_d as the MSB. With `fld_t` = 0 the four indices are d, d+1, d+2, d+3. With `fld_t` = 1 they are d, d+2, d+4, d+6. They are written in that order, one element each.
- R5: If the last destination index would exceed 31, the operation ends with `unpred_flag` during `done`. No read, register write or writeback takes place.
- R6: With `fld_a` = 1 the base must be a multiple of 4 (size 00), 8 (sizes 01 and 10) or 16 (size 11). Otherwise `align_fault` is raised during `done`, with no read, write or writeback. With `fld_a` = 0 the alignment is not checked.
- R7: Element i is requested at base + i×ebytes, in order i = 0..3. It is taken little-endian from the low ebytes bytes of `rsp_data`, and the upper bytes are ignored.
- R8: `fld_rm` = 1111 gives no base writeback. `fld_rm` = 1101 writes base + 4×ebytes to register `fld_rn`. Any other `fld_rm` writes base + `index_val` to `fld_rn`.
- R9: All four register writes follow the fourth read response. The writeback follows the last register write. `done` is a single-cycle pulse after all of them.
- R10: `busy` is high from the cycle after `start` is accepted through the `done` cycle. A `start` seen while `busy` is high is ignored.
- R11: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_addr` stay unchanged in the next cycle.
- R12: The outcome flags are mutually exclusive. The undefined encoding takes priority over the register range, and the register range takes priority over alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| fld_d | input | 1 | MSB of first destination index |
| fld_vd | input | 4 | Low bits of first destination index |
| fld_size | input | 2 | Element size code |
| fld_t | input | 1 | Register spacing: 0 single, 1 double |
| fld_a | input | 1 | Alignment check enable |
| fld_rn | input | 4 | Base register number |
| fld_rm | input | 4 | Writeback mode / index register number |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| undef_flag | output | 1 | Undefined encoding (valid with done) |
| unpred_flag | output | 1 | Register range overflow (valid with done) |
| align_fault | output | 1 | Misaligned base (valid with done) |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 32 | Read byte address |
| rd_bytes | output | 3 | Bytes in the requested element |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Read data, element in low bytes |
| rf_we | output | 1 | Vector register write strobe |
| rf_idx | output | 5 | Vector register index |
| rf_data | output | 64 | Replicated register value |
| wb_en | output | 1 | Base writeback strobe |
| wb_idx | output | 4 | Base register number |
| wb_data | output | 32 | Updated base value |

## Verification
On every cycle the assertions check these properties:
- the request stays stable under back-pressure;
- `done` lasts exactly one cycle and arrives inside `busy`;
- the outcome flags stay exclusive;
- no register write comes before four responses;
- exactly four writes precede a clean `done`, and none precede a flagged one.

Only the bench scenarios can show the values themselves: the lane replication for each size, the index sequence for both spacings, the addresses and their order, the writeback value in each mode, the boundary indices 31 and 32, the priority between flags, and that a start issued mid-operation leaves no trace.

// File: rtl/qsl_pkg.sv
package qsl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_REQ,
    ST_WAIT,
    ST_WRITE,
    ST_WB,
    ST_DONE
  } qsl_state_e;

  typedef struct packed {
    logic       d;
    logic [3:0] vd;
    logic [1:0] size;
    logic       t;
    logic       a;
    logic [3:0] rn;
    logic [3:0] rm;
  } qsl_fields_t;

  localparam logic [3:0] RM_NO_WB   = 4'hF;
  localparam logic [3:0] RM_STEP_WB = 4'hD;

endpackage

// File: rtl/qsl_decode.sv
module qsl_decode
  import qsl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5,
  parameter int ELEMS  = 4,
  parameter int NREG   = 32
) (
  input  qsl_fields_t       f,
  input  logic [ADDR_W-1:0] base,
  output logic [2:0]        ebytes,
  output logic [IDX_W-1:0]  first_idx,
  output logic [1:0]        step,
  output logic              is_undef,
  output logic              is_unpred,
  output logic              is_misaligned
);
  localparam int LAST_W = IDX_W + 3;

  logic [ADDR_W-1:0] amask;
  logic [LAST_W-1:0] last_idx;

  always_comb begin
    unique case (f.size)
      2'b00:   begin ebytes = 3'd1; amask = ADDR_W'(3);  end
      2'b01:   begin ebytes = 3'd2; amask = ADDR_W'(7);  end
      2'b10:   begin ebytes = 3'd4; amask = ADDR_W'(7);  end
      default: begin ebytes = 3'd4; amask = ADDR_W'(15); end
    endcase
  end

  assign first_idx     = IDX_W'({f.d, f.vd});
  assign step          = f.t ? 2'd2 : 2'd1;
  assign last_idx      = LAST_W'(first_idx) + LAST_W'(ELEMS - 1) * LAST_W'(step);
  assign is_unpred     = last_idx > LAST_W'(NREG - 1);
  assign is_undef      = (f.size == 2'b11) && !f.a;
  assign is_misaligned = f.a && (|(base & amask));

endmodule

// File: rtl/qsl_splat.sv
module qsl_splat #(
  parameter int REG_W = 64
) (
  input  logic [31:0]      elem,
  input  logic [1:0]       size,
  output logic [REG_W-1:0] lanes
);
  localparam int N8  = REG_W / 8;
  localparam int N16 = REG_W / 16;
  localparam int N32 = REG_W / 32;

  logic [REG_W-1:0] rep8, rep16, rep32;

  for (genvar g = 0; g < N8; g++) begin : g_b8
    assign rep8[g*8 +: 8] = elem[7:0];
  end
  for (genvar g = 0; g < N16; g++) begin : g_b16
    assign rep16[g*16 +: 16] = elem[15:0];
  end
  for (genvar g = 0; g < N32; g++) begin : g_b32
    assign rep32[g*32 +: 32] = elem;
  end

  always_comb begin
    unique case (size)
      2'b00:   lanes = rep8;
      2'b01:   lanes = rep16;
      default: lanes = rep32;
    endcase
  end

endmodule

// File: rtl/qsl_addr.sv
module qsl_addr
  import qsl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ELEMS  = 4,
  parameter int CNT_W  = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index_val,
  input  logic [2:0]        ebytes,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [3:0]        rm,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wb_val
);
  logic [ADDR_W-1:0] stride;

  assign rd_addr = base + ADDR_W'(cnt) * ADDR_W'(ebytes);
  assign stride  = ADDR_W'(ELEMS) * ADDR_W'(ebytes);
  assign wb_val  = (rm == RM_STEP_WB) ? base + stride : base + index_val;

endmodule

// File: rtl/quad_splat_loader.sv
module quad_splat_loader
  import qsl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 64,
  parameter int NREG   = 32,
  parameter int ELEMS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fld_d,
  input  logic [3:0]        fld_vd,
  input  logic [1:0]        fld_size,
  input  logic              fld_t,
  input  logic              fld_a,
  input  logic [3:0]        fld_rn,
  input  logic [3:0]        fld_rm,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] index_val,
  output logic              busy,
  output logic              done,
  output logic              undef_flag,
  output logic              unpred_flag,
  output logic              align_fault,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [2:0]        rd_bytes,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_data,
  output logic              rf_we,
  output logic [4:0]        rf_idx,
  output logic [REG_W-1:0]  rf_data,
  output logic              wb_en,
  output logic [3:0]        wb_idx,
  output logic [ADDR_W-1:0] wb_data
);
  localparam int IDX_W = $clog2(NREG);
  localparam int CNT_W = $clog2(ELEMS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ELEMS - 1);

  qsl_state_e        st;
  qsl_fields_t       fq;
  logic [ADDR_W-1:0] base_q, index_q;
  logic [CNT_W-1:0]  cnt;
  logic [31:0]       elem_q [ELEMS];
  logic              undef_q, unpred_q, fault_q;

  qsl_fields_t       fin;
  logic [2:0]        ebytes;
  logic [IDX_W-1:0]  first_idx;
  logic [1:0]        step;
  logic              is_undef, is_unpred, is_misaligned;
  logic [ADDR_W-1:0] addr_c, wb_c;
  logic [IDX_W+2:0]  idx_sum;

  assign fin = '{d: fld_d, vd: fld_vd, size: fld_size, t: fld_t, a: fld_a,
                 rn: fld_rn, rm: fld_rm};

  qsl_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ELEMS(ELEMS), .NREG(NREG)) u_dec (
    .f(fq), .base(base_q), .ebytes(ebytes), .first_idx(first_idx), .step(step),
    .is_undef(is_undef), .is_unpred(is_unpred), .is_misaligned(is_misaligned)
  );

  qsl_addr #(.ADDR_W(ADDR_W), .ELEMS(ELEMS), .CNT_W(CNT_W)) u_addr (
    .base(base_q), .index_val(index_q), .ebytes(ebytes), .cnt(cnt), .rm(fq.rm),
    .rd_addr(addr_c), .wb_val(wb_c)
  );

  qsl_splat #(.REG_W(REG_W)) u_splat (
    .elem(elem_q[cnt]), .size(fq.size), .lanes(rf_data)
  );

  // control sequence
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      fq       <= '0;
      base_q   <= '0;
      index_q  <= '0;
      cnt      <= '0;
      undef_q  <= 1'b0;
      unpred_q <= 1'b0;
      fault_q  <= 1'b0;
      for (int k = 0; k < ELEMS; k++) elem_q[k] <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          fq       <= fin;
          base_q   <= base_val;
          index_q  <= index_val;
          cnt      <= '0;
          undef_q  <= 1'b0;
          unpred_q <= 1'b0;
          fault_q  <= 1'b0;
          st       <= ST_CHECK;
        end
        ST_CHECK: begin
          if (is_undef) begin
            undef_q <= 1'b1;
            st      <= ST_DONE;
          end else if (is_unpred) begin
            unpred_q <= 1'b1;
            st       <= ST_DONE;
          end else if (is_misaligned) begin
            fault_q <= 1'b1;
            st      <= ST_DONE;
          end else begin
            st <= ST_REQ;
          end
        end
        ST_REQ: if (rd_ready) st <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          elem_q[cnt] <= rsp_data;
          if (cnt == CNT_LAST) begin
            cnt <= '0;
            st  <= ST_WRITE;
          end else begin
            cnt <= cnt + 1'b1;
            st  <= ST_REQ;
          end
        end
        ST_WRITE: begin
          if (cnt == CNT_LAST) begin
            cnt <= '0;
            st  <= ST_WB;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WB:   st <= ST_DONE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign idx_sum     = (IDX_W+3)'(first_idx) + (IDX_W+3)'(cnt) * (IDX_W+3)'(step);
  assign busy        = (st != ST_IDLE);
  assign done        = (st == ST_DONE);
  assign undef_flag  = done && undef_q;
  assign unpred_flag = done && unpred_q;
  assign align_fault = done && fault_q;
  assign rd_valid    = (st == ST_REQ);
  assign rd_addr     = addr_c;
  assign rd_bytes    = ebytes;
  assign rf_we       = (st == ST_WRITE);
  assign rf_idx      = 5'(idx_sum);
  assign wb_en       = (st == ST_WB) && (fq.rm != RM_NO_WB);
  assign wb_idx      = fq.rn;
  assign wb_data     = wb_c;

  // observation counters for the properties below
  logic [CNT_W:0] rsp_seen, wr_seen;
  always_ff @(posedge clk) begin
    if (!rst_n || (st == ST_IDLE)) begin
      rsp_seen <= '0;
      wr_seen  <= '0;
    end else begin
      if (rsp_valid && st == ST_WAIT) rsp_seen <= rsp_seen + 1'b1;
      if (rf_we)                      wr_seen  <= wr_seen + 1'b1;
    end
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_write_after_reads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rsp_seen == (CNT_W+1)'(ELEMS));

  assert_done_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({undef_flag, unpred_flag, align_fault}) <= 1);

  assert_flagged_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && (undef_flag || unpred_flag || align_fault) |-> wr_seen == '0);

  assert_clean_four_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && !(undef_flag || unpred_flag || align_fault) |-> wr_seen == (CNT_W+1)'(ELEMS));

endmodule

// File: tb/sim_quad_splat_loader.sv
module sim_quad_splat_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        fld_d = 1'b0, fld_t = 1'b0, fld_a = 1'b0;
  logic [3:0]  fld_vd = '0, fld_rn = '0, fld_rm = '0;
  logic [1:0]  fld_size = '0;
  logic [31:0] base_val = '0, index_val = '0;
  logic        busy, done, undef_flag, unpred_flag, align_fault;
  logic        rd_valid, rd_ready = 1'b0;
  logic [31:0] rd_addr;
  logic [2:0]  rd_bytes;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        rf_we, wb_en;
  logic [4:0]  rf_idx;
  logic [63:0] rf_data;
  logic [3:0]  wb_idx;
  logic [31:0] wb_data;

  always #2 clk = ~clk;

  quad_splat_loader u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .fld_d(fld_d), .fld_vd(fld_vd),
    .fld_size(fld_size), .fld_t(fld_t), .fld_a(fld_a), .fld_rn(fld_rn), .fld_rm(fld_rm),
    .base_val(base_val), .index_val(index_val), .busy(busy), .done(done),
    .undef_flag(undef_flag), .unpred_flag(unpred_flag), .align_fault(align_fault),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_bytes(rd_bytes),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rf_we(rf_we), .rf_idx(rf_idx),
    .rf_data(rf_data), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  int checks = 0, errors = 0, done_cnt = 0, cyc = 0;
  logic [31:0] exp_addr[$];
  logic [2:0]  exp_bytes[$];
  logic [4:0]  exp_idx[$];
  logic [63:0] exp_data[$];
  logic [3:0]  exp_wbi[$];
  logic [31:0] exp_wbd[$];
  logic [2:0]  exp_flags[$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(input logic [31:0] a);
    logic [7:0] v;
    v = a[7:0] * 8'd37;
    return v + a[15:8] + 8'd11;
  endfunction

  // memory responder: back-pressure and variable latency
  int          pend = 0;
  logic [31:0] pend_addr = '0;
  always @(negedge clk) begin
    cyc++;
    rsp_valid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        rsp_valid = 1'b1;
        rsp_data  = {mb(pend_addr + 3), mb(pend_addr + 2), mb(pend_addr + 1), mb(pend_addr)};
      end
    end
    rd_ready = (cyc % 4) != 2;
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_addr.size() == 0) check(0, "R2/R5/R6 unexpected read", rd_addr, 0);
      else begin
        logic [31:0] ea;
        logic [2:0]  eb;
        ea = exp_addr.pop_front();
        eb = exp_bytes.pop_front();
        check(rd_addr == ea, "R7 read address", rd_addr, ea);
        check(rd_bytes == eb, "R1 element bytes", rd_bytes, eb);
      end
      pend_addr = rd_addr;
      pend = 1 + (cyc % 3);
    end
  end

  // monitor: compares outputs against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rf_we) begin
      check(exp_addr.size() == 0 && pend == 0, "R9 write before reads done", pend, 0);
      if (exp_idx.size() == 0) check(0, "R10 unexpected register write", rf_idx, 0);
      else begin
        logic [4:0]  ei;
        logic [63:0] ed;
        ei = exp_idx.pop_front();
        ed = exp_data.pop_front();
        check(rf_idx == ei, "R4 destination index", rf_idx, ei);
        check(rf_data == ed, "R3 replicated data", rf_data, ed);
      end
    end
    if (rst_n && wb_en) begin
      check(exp_idx.size() == 0, "R9 writeback before register writes", exp_idx.size(), 0);
      if (exp_wbi.size() == 0) check(0, "R8 unexpected writeback", wb_data, 0);
      else begin
        logic [3:0]  wi;
        logic [31:0] wd;
        wi = exp_wbi.pop_front();
        wd = exp_wbd.pop_front();
        check(wb_idx == wi, "R8 writeback register", wb_idx, wi);
        check(wb_data == wd, "R8 writeback value", wb_data, wd);
      end
    end
    if (rst_n && done) begin
      check(exp_idx.size() == 0 && exp_wbi.size() == 0, "R9 done before all writes",
            exp_idx.size() + exp_wbi.size(), 0);
      if (exp_flags.size() == 0) check(0, "R10 unexpected done", 1, 0);
      else begin
        logic [2:0] ef;
        ef = exp_flags.pop_front();
        check({undef_flag, unpred_flag, align_fault} == ef, "R2/R5/R6/R12 outcome flags",
              {undef_flag, unpred_flag, align_fault}, ef);
      end
      done_cnt++;
    end
  end

  task automatic drive(input logic [4:0] dv, input logic [1:0] sz, input logic t, input logic a,
                       input logic [3:0] rn, input logic [3:0] rm, input logic [31:0] b,
                       input logic [31:0] ix);
    fld_d = dv[4]; fld_vd = dv[3:0]; fld_size = sz; fld_t = t; fld_a = a;
    fld_rn = rn; fld_rm = rm; base_val = b; index_val = ix;
  endtask

  task automatic run_op(input logic [4:0] dv, input logic [1:0] sz, input logic t, input logic a,
                        input logic [3:0] rn, input logic [3:0] rm, input logic [31:0] b,
                        input logic [31:0] ix, input bit intrude);
    int eb, stp, last, target;
    logic [31:0] mask;
    bit und, unp, flt;
    eb   = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    mask = (sz == 2'b00) ? 32'd3 : (sz == 2'b11) ? 32'd15 : 32'd7;
    stp  = t ? 2 : 1;
    last = int'(dv) + 3 * stp;
    und  = (sz == 2'b11) && !a;
    unp  = !und && last > 31;
    flt  = !und && !unp && a && ((b & mask) != 0);
    exp_flags.push_back({und, unp, flt});
    if (!und && !unp && !flt) begin
      for (int i = 0; i < 4; i++) begin
        logic [31:0] ea;
        logic [63:0] r;
        ea = b + i * eb;
        exp_addr.push_back(ea);
        exp_bytes.push_back(3'(eb));
        for (int l = 0; l < 8 / eb; l++)
          for (int k = 0; k < eb; k++) r[(l * eb + k) * 8 +: 8] = mb(ea + k);
        exp_idx.push_back(5'(int'(dv) + i * stp));
        exp_data.push_back(r);
      end
      if (rm != 4'hF) begin
        exp_wbi.push_back(rn);
        exp_wbd.push_back(rm == 4'hD ? b + 4 * eb : b + ix);
      end
    end
    target = done_cnt + 1;
    @(negedge clk);
    drive(dv, sz, t, a, rn, rm, b, ix);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      repeat (3) @(negedge clk);
      check(busy == 1'b1, "R10 busy during operation", busy, 1);
      drive(5'd2, 2'b00, 1'b0, 1'b0, 4'd9, 4'hD, 32'h7000, 32'h0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (done_cnt >= target);
    @(negedge clk);
    check(busy == 1'b0, "R10 busy clear after done", busy, 0);
    repeat (4) @(negedge clk);
    check(done_cnt == target, "R10 ignored start left no operation", done_cnt, target);
    check(exp_addr.size() == 0 && exp_flags.size() == 0, "R9 scoreboard drained",
          exp_addr.size() + exp_flags.size(), 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !rf_we && !rd_valid && !wb_en, "R10 reset state",
          {busy, done, rf_we, rd_valid, wb_en}, 0);
    // R1 R3 R4 R7: bytes, single spaced, no alignment check on odd base, no writeback (R8)
    run_op(5'd2, 2'b00, 1'b0, 1'b0, 4'd1, 4'hF, 32'h1003, 32'h0, 0);
    // R8 step writeback, halfwords, double spaced, aligned
    run_op(5'd16, 2'b01, 1'b1, 1'b1, 4'd3, 4'hD, 32'h2008, 32'h0, 0);
    // R8 index writeback, words
    run_op(5'd4, 2'b10, 1'b0, 1'b1, 4'd7, 4'd5, 32'h3010, 32'h40, 0);
    // R4 R5 boundary: last index exactly 31, size 11 with 16-byte alignment
    run_op(5'd25, 2'b11, 1'b1, 1'b1, 4'd2, 4'hD, 32'h4020, 32'h0, 0);
    run_op(5'd28, 2'b00, 1'b0, 1'b0, 4'd4, 4'd6, 32'h500, 32'hFFFF_FFFC, 0);
    // R2 undefined
    run_op(5'd0, 2'b11, 1'b0, 1'b0, 4'd1, 4'hD, 32'h4000, 32'h0, 0);
    // R5 overflow, single and double spacing
    run_op(5'd29, 2'b00, 1'b0, 1'b0, 4'd1, 4'hD, 32'h100, 32'h0, 0);
    run_op(5'd26, 2'b01, 1'b1, 1'b0, 4'd1, 4'hD, 32'h100, 32'h0, 0);
    // R6 alignment faults
    run_op(5'd0, 2'b01, 1'b0, 1'b1, 4'd1, 4'hD, 32'h2004, 32'h0, 0);
    run_op(5'd0, 2'b00, 1'b0, 1'b1, 4'd1, 4'hD, 32'h0102, 32'h0, 0);
    run_op(5'd0, 2'b11, 1'b0, 1'b1, 4'd1, 4'hD, 32'h4028, 32'h0, 0);
    // R12 priority
    run_op(5'd30, 2'b11, 1'b0, 1'b0, 4'd1, 4'hD, 32'h4001, 32'h0, 0);
    run_op(5'd30, 2'b00, 1'b0, 1'b1, 4'd1, 4'hD, 32'h0001, 32'h0, 0);
    // R10 start while busy is ignored
    run_op(5'd8, 2'b10, 1'b1, 1'b0, 4'd5, 4'd3, 32'h6004, 32'h20, 1);
    finish_run();
  end
endmodule